// File: doc/BRIEF.md
# Real-Time Clock Timebase with Alarms

This block is the timekeeping core of a real-time clock. It runs on the 32.768 kHz clock. A prescaler divides that clock down to a 256 Hz tick. Each tick advances an 8-bit fraction-of-second counter. When that counter wraps, it carries into a 32-bit seconds counter. Software, or the block around this one, can preload either counter at any time. A single enable freezes or releases the whole timebase.

Two alarms sit next to the counters.
- The match alarm compares the low 20 bits of the seconds count against a programmed value. The comparison is made at the moment the seconds count advances.
- The periodic alarm counts 256 Hz ticks down from a programmed reload value. It fires every reload-many ticks.

Each alarm keeps a sticky pending flag, which only its own clear pulse removes. A combined wake request is raised for any pending flag whose alarm is enabled. A one-cycle update pulse marks every change of the count registers.

Top module: `rtc_timebase`

## Requirements
- R1: While `run_en` is high and no preload is requested, `frac_count` advances by one every `PRESCALE` clock cycles. The default of 128 gives 256 Hz from a 32.768 kHz clock. The count wraps from 0xFF to 0x00.
- R2: `sec_count` increments by one, modulo 2^32, exactly on the edge where `frac_count` wraps from 0xFF to 0x00, and on no other counting edge.
- R3: With `run_en` low, `frac_count`, `sec_count` and the prescaler hold their values. Counting resumes from the same phase.
- R4: A high `sec_load` or `frac_load` loads `sec_load_val` or `frac_load_val` on the next edge and clears the prescaler. That edge does not count, and the first tick after it comes `PRESCALE` edges later.
- R5: A preload never raises the match alarm flag, even when the loaded value matches.
- R6: `match_flag` is set on the counting edge where the new `sec_count[19:0]` equals `match_val`, but only if `match_en` is high. Bits 31:20 of the seconds count do not take part in the comparison.
- R7: While `period_en` is low, the periodic countdown holds `period_reload`. Once it is enabled, `period_flag` is set on the R-th tick and again every R ticks after that, where R is the reload value. A reload of 0 behaves as 1.
- R8: Both flags stay set until their own clear pulse (`match_clr`, `period_clr`). A set on the same edge as a clear wins.
- R9: `wake_req` is high exactly when (`match_flag` and `match_en`) or (`period_flag` and `period_en`) is true.
- R10: `update_pulse` is high for one cycle, together with the new count values, after every tick or preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counter enable |
| match_en | input | 1 | Match alarm enable |
| period_en | input | 1 | Periodic alarm enable |
| match_val | input | 20 | Match alarm compare value |
| period_reload | input | 32 | Periodic alarm reload, in ticks |
| sec_load | input | 1 | Seconds preload strobe |
| sec_load_val | input | 32 | Seconds preload value |
| frac_load | input | 1 | Fraction preload strobe |
| frac_load_val | input | 8 | Fraction preload value |
| match_clr | input | 1 | Clear pulse for match flag |
| period_clr | input | 1 | Clear pulse for periodic flag |
| frac_count | output | 8 | Fraction-of-second count |
| sec_count | output | 32 | Seconds count |
| match_flag | output | 1 | Sticky match alarm pending |
| period_flag | output | 1 | Sticky periodic alarm pending |
| update_pulse | output | 1 | One-cycle count update marker |
| wake_req | output | 1 | Combined interrupt / wake request |

## Verification
The bench builds the block with a small prescaler (4), so carries and alarm periods are reached in tens of cycles rather than tens of thousands.

The hardest states to reach are the carry edges: a fraction wrap that also wraps all 32 seconds bits, and a match whose upper seconds bits differ from zero. Without preload these would take years of counting. The bench instead preloads the counters to just below each boundary, with the prescaler cleared, so the exact edge of the carry is known. It then sweeps starting points and wait lengths, and compares the counts against quotient-and-remainder arithmetic.

The periodic alarm is started together with a fraction preload, so its phase is known. It is then checked one cycle before and on each expected firing, for several reload values including zero.

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int PRESCALE = 128,
  parameter int FRAC_W   = 8,
  parameter int SEC_W    = 32,
  parameter int MATCH_W  = 20,
  parameter int RLD_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               match_en,
  input  logic               period_en,
  input  logic [MATCH_W-1:0] match_val,
  input  logic [RLD_W-1:0]   period_reload,
  input  logic               sec_load,
  input  logic [SEC_W-1:0]   sec_load_val,
  input  logic               frac_load,
  input  logic [FRAC_W-1:0]  frac_load_val,
  input  logic               match_clr,
  input  logic               period_clr,
  output logic [FRAC_W-1:0]  frac_count,
  output logic [SEC_W-1:0]   sec_count,
  output logic               match_flag,
  output logic               period_flag,
  output logic               update_pulse,
  output logic               wake_req
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;
  logic [RLD_W-1:0] down_q;

  wire              load_any  = sec_load | frac_load;
  wire              tick      = run_en && !load_any && (pre_q == PRE_LAST);
  wire              carry     = tick && (frac_count == '1);
  wire [SEC_W-1:0]  sec_next  = sec_count + SEC_W'(1);
  wire              match_hit = carry && match_en && (sec_next[MATCH_W-1:0] == match_val);
  wire              down_end  = (down_q <= RLD_W'(1));
  wire              per_hit   = tick && period_en && down_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q        <= '0;
      frac_count   <= '0;
      sec_count    <= '0;
      down_q       <= '0;
      match_flag   <= 1'b0;
      period_flag  <= 1'b0;
      update_pulse <= 1'b0;
    end else begin
      if (load_any)
        pre_q <= '0;
      else if (run_en)
        pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);

      if (frac_load)
        frac_count <= frac_load_val;
      else if (tick)
        frac_count <= frac_count + FRAC_W'(1);

      if (sec_load)
        sec_count <= sec_load_val;
      else if (carry)
        sec_count <= sec_next;

      if (!period_en)
        down_q <= period_reload;
      else if (tick)
        down_q <= down_end ? period_reload : down_q - RLD_W'(1);

      match_flag   <= match_hit | (match_flag & ~match_clr);
      period_flag  <= per_hit | (period_flag & ~period_clr);
      update_pulse <= tick | load_any;
    end
  end

  assign wake_req = (match_flag & match_en) | (period_flag & period_en);
endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        match_en,
  input logic        sec_load,
  input logic        frac_load,
  input logic        match_clr,
  input logic        period_clr,
  input logic [7:0]  frac_count,
  input logic [31:0] sec_count,
  input logic        match_flag,
  input logic        period_flag
);
  assert_carry_only_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_load && !frac_load) |=> (sec_count == $past(sec_count)) ||
      (sec_count == $past(sec_count) + 32'd1 && $past(frac_count) == 8'hFF && frac_count == 8'h00));

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !sec_load && !frac_load) |=> ($stable(frac_count) && $stable(sec_count)));

  assert_frac_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frac_load) |=> (frac_count == $past(frac_count) || frac_count == $past(frac_count) + 8'd1));

  assert_match_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(match_en));

  assert_no_match_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_load && !match_flag) |=> !match_flag);

  assert_match_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);

  assert_period_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (period_flag && !period_clr) |=> period_flag);
endmodule

bind rtc_timebase rtc_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .match_en(match_en),
  .sec_load(sec_load), .frac_load(frac_load),
  .match_clr(match_clr), .period_clr(period_clr),
  .frac_count(frac_count), .sec_count(sec_count),
  .match_flag(match_flag), .period_flag(period_flag)
);

// File: tb/test_rtc_timebase.sv
`timescale 1ns/1ps
module test_rtc_timebase;
  localparam int PS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 0, match_en = 0, period_en = 0;
  logic [19:0] match_val = '0;
  logic [31:0] period_reload = '0;
  logic        sec_load = 0, frac_load = 0;
  logic [31:0] sec_load_val = '0;
  logic [7:0]  frac_load_val = '0;
  logic        match_clr = 0, period_clr = 0;
  logic [7:0]  frac_count;
  logic [31:0] sec_count;
  logic        match_flag, period_flag, update_pulse, wake_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_timebase #(.PRESCALE(PS)) i_rtc_timebase (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .match_en(match_en),
    .period_en(period_en), .match_val(match_val), .period_reload(period_reload),
    .sec_load(sec_load), .sec_load_val(sec_load_val),
    .frac_load(frac_load), .frac_load_val(frac_load_val),
    .match_clr(match_clr), .period_clr(period_clr),
    .frac_count(frac_count), .sec_count(sec_count),
    .match_flag(match_flag), .period_flag(period_flag),
    .update_pulse(update_pulse), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preload(input logic [31:0] s, input logic [7:0] f);
    sec_load_val = s; frac_load_val = f; sec_load = 1; frac_load = 1;
    @(negedge clk);
    sec_load = 0; frac_load = 0;
  endtask

  task automatic pulse_clear();
    match_clr = 1; period_clr = 1;
    @(negedge clk);
    match_clr = 0; period_clr = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  sf;
    logic [31:0] s0;
    int          ticks;
    repeat (3) @(negedge clk);
    chk("R1 reset frac", frac_count, 0);
    chk("R2 reset sec", sec_count, 0);
    chk("R8 reset flags", {match_flag, period_flag}, 0);
    chk("R9 reset wake", wake_req, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: stopped timebase holds
    preload(32'h0000_0010, 8'h20);
    wait_n(20);
    chk("R3 hold frac", frac_count, 8'h20);
    chk("R3 hold sec", sec_count, 32'h10);

    // R10: update pulse on preload and tick
    run_en = 1;
    preload(32'h0, 8'h00);
    chk("R10 pulse after load", update_pulse, 1);
    wait_n(1);
    chk("R10 pulse one cycle", update_pulse, 0);
    wait_n(3);
    chk("R10 pulse with tick", {update_pulse, frac_count}, {1'b1, 8'h01});

    // R1 R2 R4 sweep of starting points and waits
    foreach (sweep_f[i]) begin
      foreach (sweep_n[j]) begin
        s0 = 32'h0000_1234 + 32'(i);
        preload(s0, sweep_f[i]);
        wait_n(sweep_n[j]);
        ticks = sweep_n[j] / PS;
        sf = 8'((int'(sweep_f[i]) + ticks) % 256);
        chk("R1 frac sweep", frac_count, sf);
        chk("R2 sec sweep", sec_count, s0 + 32'((int'(sweep_f[i]) + ticks) / 256));
      end
    end

    // R2: full 32-bit wrap
    preload(32'hFFFF_FFFF, 8'hFF);
    wait_n(PS - 1);
    chk("R4 no early tick", {sec_count, frac_count}, {32'hFFFF_FFFF, 8'hFF});
    wait_n(1);
    chk("R2 sec wraps", {sec_count, frac_count}, {32'h0, 8'h00});

    // R3: pause and resume keeps phase
    preload(32'h5, 8'h10);
    wait_n(2);
    run_en = 0;
    wait_n(10);
    run_en = 1;
    wait_n(1);
    chk("R3 phase kept", frac_count, 8'h10);
    wait_n(1);
    chk("R3 resume tick", frac_count, 8'h11);

    // R5 R6: match alarm
    match_val = 20'h00005;
    match_en = 1;
    preload(32'h5, 8'h00);
    wait_n(2);
    chk("R5 load no match", match_flag, 0);
    preload(32'h4, 8'hFE);
    wait_n(2 * PS - 1);
    chk("R6 before match", match_flag, 0);
    wait_n(1);
    chk("R6 match set", {sec_count, match_flag}, {32'h5, 1'b1});
    chk("R9 wake match", wake_req, 1);
    match_en = 0;
    #1;
    chk("R9 wake masked", {wake_req, match_flag}, {1'b0, 1'b1});
    pulse_clear();
    chk("R8 match cleared", match_flag, 0);
    match_en = 1;
    preload(32'h0010_0004, 8'hFF);
    wait_n(PS);
    chk("R6 upper bits ignored", match_flag, 1);
    pulse_clear();
    match_en = 0;
    preload(32'h4, 8'hFF);
    wait_n(PS);
    chk("R6 disabled no flag", {sec_count, match_flag}, {32'h5, 1'b0});

    // R7 R8: periodic alarm
    foreach (sweep_r[k]) begin
      period_reload = sweep_r[k];
      pulse_clear();
      period_en = 1;
      preload(32'h0, 8'h00);
      ticks = (sweep_r[k] == 0) ? 1 : int'(sweep_r[k]);
      wait_n(PS * ticks - 1);
      chk("R7 before period", period_flag, 0);
      wait_n(1);
      chk("R7 period fires", period_flag, 1);
      chk("R9 wake period", wake_req, 1);
      match_clr = 0; period_clr = 1;
      @(negedge clk);
      period_clr = 0;
      chk("R8 period cleared", period_flag, 0);
      wait_n(PS * ticks - 2);
      chk("R7 before repeat", period_flag, 0);
      wait_n(1);
      chk("R7 period repeats", period_flag, 1);
      period_en = 0;
      #1;
      chk("R9 period masked", wake_req, 0);
    end
    pulse_clear();
    period_reload = 32'd1;
    wait_n(4 * PS);
    chk("R7 disabled no flag", period_flag, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [7:0]  sweep_f [4] = '{8'h00, 8'h80, 8'hFE, 8'hFF};
  int          sweep_n [6] = '{0, 3, 4, 7, 8, 40};
  logic [31:0] sweep_r [4] = '{32'd0, 32'd1, 32'd3, 32'd5};
endmodule